// File: doc/BRIEF.md
# Parallel Self-Synchronizing Lane Descrambler

This block removes self-synchronizing scrambling from a serial lane that arrives 16 bits per clock. The scrambler polynomial is 1 + x^14 + x^15. Each recovered bit is the received scrambled bit XORed with the two scrambled bits that arrived 14 and 15 bit-times before it. Within a word, bit 15 is the earliest bit in time and bit 0 is the latest. The feedback taps therefore chain through the current word and reach back into a 15-bit history of earlier scrambled bits.

The history is built only from received data. The block needs no seed and no handshake with the transmitter. After reset, or after any corruption on the line, it becomes correct again by itself once 15 clean scrambled bits have passed. A bypass control forwards the raw word unchanged. The history keeps tracking the line while bypass is set, so leaving bypass gives correct output on the very next word. The output is registered, with one cycle of latency, and the valid flag is delayed to match.

Top module: `lane_descrambler`

## Requirements
- R1: When the input is produced by a matching 1 + x^14 + x^15 scrambler, every output word from the second valid word onward equals the original data, whatever the starting states of the scrambler and the descrambler. This holds for every 16-bit data value.
- R2: With bypass low, output bit i equals the input bit at stream position p XORed with the scrambled bits at positions p-14 and p-15. Here bit 15 of a word comes first in time, and bits from earlier valid words precede the current word.
- R3: out_valid equals in_valid from the previous clock, which gives one register stage of latency.
- R4: When a valid word arrives with bypass high, the next out_word equals that input word unchanged.
- R5: The 15-bit history is updated on valid words even while bypass is high. The first descrambled word after bypass is released is therefore fully correct.
- R6: A cycle with in_valid low does not change out_word or the history. Garbage on in_word during such a cycle has no effect on later output.
- R7: While reset is asserted, out_valid is 0 and out_word is 0. The history reads as all zeros for the first word after reset.
- R8: A single corrupted input word affects at most that word and the next one. The valid word after those two is correct again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 16 | Scrambled lane word, bit 15 earliest in time |
| in_valid | input | 1 | in_word carries a lane word this cycle |
| bypass | input | 1 | Forward in_word without descrambling |
| out_word | output | 16 | Descrambled (or bypassed) word, one cycle later |
| out_valid | output | 1 | out_word was loaded on the previous edge |

## Verification
The assertions run on every cycle and check the following:
- the one-cycle delay of valid;
- the pass-through on bypassed words;
- that out_word holds across idle cycles;
- the tap equation for the latest bit of each word, whose taps lie entirely inside the same word.

The bench scenarios are needed for everything that depends on the stored history. That covers the full tap equation across word boundaries, round trips through a scrambler from arbitrary seeds and over all 65536 data values, and recovery after a corrupted word. It also covers the history tracking the line during bypass and staying untouched by idle-cycle garbage.

// File: rtl/lane_descrambler.sv
module lane_descrambler #(
  parameter int WIDTH    = 16,
  parameter int TAP_NEAR = 14,
  parameter int TAP_FAR  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_word,
  input  logic             in_valid,
  input  logic             bypass,
  output logic [WIDTH-1:0] out_word,
  output logic             out_valid
);
  localparam int HIST = TAP_FAR;
  localparam int EXTW = HIST + WIDTH;

  logic [HIST-1:0]  hist_q;
  logic [EXTW-1:0]  stream;
  logic [WIDTH-1:0] plain;

  // Higher index = earlier in time; history sits above the current word.
  assign stream = {hist_q, in_word};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign plain[i] = stream[i] ^ stream[i+TAP_NEAR] ^ stream[i+TAP_FAR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q    <= '0;
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist_q   <= stream[HIST-1:0];
        out_word <= bypass ? in_word : plain;
      end
    end
  end
endmodule

// File: rtl/lane_descrambler_chk.sv
module lane_descrambler_chk #(
  parameter int WIDTH    = 16,
  parameter int TAP_NEAR = 14,
  parameter int TAP_FAR  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] in_word,
  input logic             in_valid,
  input logic             bypass,
  input logic [WIDTH-1:0] out_word,
  input logic             out_valid
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_valid == $past(in_valid)));

  assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_valid && bypass)) |-> (out_word == $past(in_word)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(in_valid)) |-> $stable(out_word));

  if (WIDTH > TAP_FAR) begin : g_inword
    assert_latest_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(in_valid && !bypass)) |->
        (out_word[0] == $past(in_word[0] ^ in_word[TAP_NEAR] ^ in_word[TAP_FAR])));
  end
endmodule

bind lane_descrambler lane_descrambler_chk #(
  .WIDTH(WIDTH), .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
  .bypass(bypass), .out_word(out_word), .out_valid(out_valid)
);

// File: tb/lane_descrambler_tb_top.sv
module lane_descrambler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        bypass = 1'b0;
  logic [15:0] out_word;
  logic        out_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [14:0] tx_hist;  // scrambler stream history, [0] most recent
  logic [14:0] rx_hist;  // received-stream model for R2

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_descrambler dut_i (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .bypass(bypass), .out_word(out_word), .out_valid(out_valid)
  );

  function automatic logic [15:0] scramble(input logic [15:0] d);
    logic [15:0] s;
    for (int i = 15; i >= 0; i--) begin
      s[i] = d[i] ^ tx_hist[13] ^ tx_hist[14];
      tx_hist = {tx_hist[13:0], s[i]};
    end
    return s;
  endfunction

  function automatic logic [15:0] ref_descramble(input logic [15:0] s);
    logic [15:0] d;
    for (int i = 15; i >= 0; i--) begin
      d[i] = s[i] ^ rx_hist[13] ^ rx_hist[14];
      rx_hist = {rx_hist[13:0], s[i]};
    end
    return d;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic v, input logic b);
    @(negedge clk);
    in_word = w; in_valid = v; bypass = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [15:0] d, s, held;
    repeat (3) @(posedge clk);
    #1;
    check("R7 out_valid in reset", {15'b0, out_valid}, 16'h0);
    check("R7 out_word in reset", out_word, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R7: tap equation across word boundaries, history zero after reset
    rx_hist = '0;
    for (int k = 0; k < 300; k++) begin
      s = 16'($urandom);
      step(s, 1'b1, 1'b0);
      check("R2 tap equation", out_word, ref_descramble(s));
      check("R3 valid delay", {15'b0, out_valid}, 16'h1);
    end
    step(16'h0, 1'b0, 1'b0);
    check("R3 valid drops", {15'b0, out_valid}, 16'h0);

    // R1: round trip from arbitrary scrambler seeds
    for (int seed = 0; seed < 40; seed++) begin
      tx_hist = 15'($urandom);
      for (int k = 0; k < 40; k++) begin
        d = 16'($urandom);
        step(scramble(d), 1'b1, 1'b0);
        if (k == 0) check("R1 latest bit of first word", {15'b0, out_word[0]}, {15'b0, d[0]});
        else        check("R1 round trip", out_word, d);
      end
    end

    // R1: exhaustive sweep of data values
    tx_hist = 15'h5A3C;
    step(scramble(16'h0), 1'b1, 1'b0);
    for (int v = 0; v < 65536; v++) begin
      d = 16'(v);
      step(scramble(d), 1'b1, 1'b0);
      check("R1 exhaustive round trip", out_word, d);
    end

    // R6: idle cycles with garbage leave output and history untouched
    for (int k = 0; k < 30; k++) begin
      d = 16'($urandom);
      step(scramble(d), 1'b1, 1'b0);
      held = out_word;
      for (int j = 0; j < 3; j++) begin
        step(16'($urandom), 1'b0, 1'($urandom));
        check("R6 output held on idle", out_word, held);
        check("R3 valid low on idle", {15'b0, out_valid}, 16'h0);
      end
      d = 16'($urandom);
      step(scramble(d), 1'b1, 1'b0);
      check("R6 history unchanged by idle", out_word, d);
    end

    // R4 / R5: bypass passes raw words; history keeps tracking
    for (int k = 0; k < 30; k++) begin
      for (int j = 0; j < 4; j++) begin
        s = scramble(16'($urandom));
        step(s, 1'b1, 1'b1);
        check("R4 bypass passthrough", out_word, s);
      end
      d = 16'($urandom);
      step(scramble(d), 1'b1, 1'b0);
      check("R5 first word after bypass", out_word, d);
    end

    // R8: recovery after a corrupted word
    for (int k = 0; k < 50; k++) begin
      s = scramble(16'($urandom)) ^ (16'h1 << (k % 16));
      step(s, 1'b1, 1'b0);
      step(scramble(16'($urandom)), 1'b1, 1'b0);
      d = 16'($urandom);
      step(scramble(d), 1'b1, 1'b0);
      check("R8 recovered after corruption", out_word, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule